// File: doc/BRIEF.md
# Lockable Pin Override with Polarity Control

This block sits in the path from four raw front-panel inputs (a power button and three keyboard lines) to their passthrough outputs. It also drives two active-low outputs that have no matching input: a reset line for an external controller and a flash write-protect line. Each passthrough signal can be inverted on the way in, so that all combination logic sees one polarity, and inverted again on the way out, after the override decision has been made.

Each of the six outputs has a software override made of an enable bit and a value bit. An override takes effect only when a pair of per-output legal bits allows it: one bit permits forcing a 0 and the other permits forcing a 1. The legal bits, the inversion settings and the automatic key-block setup can be frozen by a sticky lock that only reset clears. Hardware overrides have lower priority than software: an external reset request and an automatic key block. The key block forces selected key outputs to programmed values after the power button has been held down for a programmed number of cycles.

Configuration arrives through a simple write port: `cfg_addr_i` selects one of eight registers and `cfg_wdata_i` carries the value, which takes effect on the rising clock edge at which `cfg_we_i` is high.

Top module: `pin_guard`

## Requirements
- R1: With no override active, each passthrough output equals its input XOR its input-inversion bit XOR its output-inversion bit. Address 4 holds the input-inversion bits in [3:0] and the output-inversion bits in [7:4]. Bit 0 is the power button and bits 1 to 3 are keys 0 to 2.
- R2: An output whose override enable is set (address 2, lane bit) takes the override value (address 3) when the matching legal bit is set. The matching legal bit is address 0 for a value of 0 and address 1 for a value of 1. Lanes 0 to 3 are the passthrough signals, lane 4 is the reset output and lane 5 is the write-protect output.
- R3: An override whose value is not permitted by the legal bits has no effect. The output then shows the hardware override, or failing that the default.
- R4: A legal software override takes priority over the external reset request and over the automatic key block.
- R5: Output inversion is applied after the override, so an overridden passthrough output equals the override value XOR its output-inversion bit.
- R6: Writing 1 to bit 0 of address 7 sets a lock that stays set until reset. While the lock is set, writes to addresses 0, 1, 4, 5 and 6 are ignored, and writes to addresses 2 and 3 still take effect.
- R7: After reset, the reset output is low. It stays low until software clears override-enable lane 4. When it is not overridden it is high, unless `ext_rst_req_i` is high, in which case it is low.
- R8: After reset, the write-protect output is low. When it is not overridden it is 0.
- R9: Address 5 configures the automatic key block: bit 0 enables it, bits [3:1] select keys 0 to 2, and bits [6:4] give their forced values. Address 6 holds the hold time T. Once armed, if the inverted power input is sampled low at T+1 consecutive rising edges, the selected key outputs take the programmed values. Those values are then still subject to output inversion.
- R10: The key block releases in the same cycle that the inverted power input goes high.
- R11: The key block is armed only by the inverted power input having been sampled high since reset. A power input that is held low from reset never triggers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 4 | Raw inputs: bit 0 power button, bits 1-3 keys |
| ext_rst_req_i | input | 1 | Hardware request to drive the reset output low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | DBW | Configuration write data |
| pin_o | output | 4 | Passthrough outputs after override and inversion |
| xrst_l_o | output | 1 | Active-low reset output to the external controller |
| wp_l_o | output | 1 | Active-low flash write-protect output |

## Verification
The output mux is combinational from registered settings, so a corrupted legal, enable or inversion bit shows up on the affected output in the first cycle after the bad write. The bench sweeps input patterns, inversions and override combinations against a priority model, and that sweep exposes such a fault at once. A debounce counter that is off by one moves the key-block onset by one cycle, and the bench samples every cycle around the expected edge for several hold times. A lock that fails to hold appears as a changed output right after the ignored write.

// File: rtl/pin_guard_pkg.sv
// Package: shared lane indices, register addresses and the settings record.
// Assumes four passthrough lanes followed by the reset and write-protect lanes.
package pin_guard_pkg;
    localparam int NKEY      = 3;
    localparam int NPIN      = NKEY + 1;
    localparam int NLANE     = NPIN + 2;
    localparam int LANE_XRST = NPIN;
    localparam int LANE_WP   = NPIN + 1;

    typedef enum logic [2:0] {
        A_LEGAL0  = 3'd0,
        A_LEGAL1  = 3'd1,
        A_OVR_EN  = 3'd2,
        A_OVR_VAL = 3'd3,
        A_INV     = 3'd4,
        A_ABLK    = 3'd5,
        A_HOLD    = 3'd6,
        A_LOCK    = 3'd7
    } cfg_addr_e;

    typedef struct packed {
        logic [NLANE-1:0] legal0;
        logic [NLANE-1:0] legal1;
        logic [NLANE-1:0] ovr_en;
        logic [NLANE-1:0] ovr_val;
        logic [NPIN-1:0]  inv_in;
        logic [NPIN-1:0]  inv_out;
        logic             ab_en;
        logic [NKEY-1:0]  ab_mask;
        logic [NKEY-1:0]  ab_val;
    } cfg_t;
endpackage

// File: rtl/pin_guard_cfg.sv
// Settings registers with a sticky lock.
// Holds the legal masks, the overrides, the inversions and the key-block setup.
// Assumes DBW >= 8 so that every register field fits in one write word.
module pin_guard_cfg
    import pin_guard_pkg::*;
#(
    parameter int DBW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we_i,
    input  logic [2:0]     addr_i,
    input  logic [DBW-1:0] wdata_i,
    output cfg_t           cfg_o,
    output logic [DBW-1:0] hold_o,
    output logic           lock_o
);
    localparam logic [NLANE-1:0] RST_MASK = NLANE'(3) << LANE_XRST;

    cfg_t           cfg_q;
    logic [DBW-1:0] hold_q;
    logic           lock_q;

    // Register writes: protected fields change only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q         <= '0;
            cfg_q.legal0  <= RST_MASK;
            cfg_q.ovr_en  <= RST_MASK;
            hold_q        <= '0;
            lock_q        <= 1'b0;
        end else if (we_i) begin
            case (cfg_addr_e'(addr_i))
                A_LEGAL0:  if (!lock_q) cfg_q.legal0 <= wdata_i[NLANE-1:0];
                A_LEGAL1:  if (!lock_q) cfg_q.legal1 <= wdata_i[NLANE-1:0];
                A_OVR_EN:  cfg_q.ovr_en  <= wdata_i[NLANE-1:0];
                A_OVR_VAL: cfg_q.ovr_val <= wdata_i[NLANE-1:0];
                A_INV: if (!lock_q) begin
                    cfg_q.inv_in  <= wdata_i[NPIN-1:0];
                    cfg_q.inv_out <= wdata_i[2*NPIN-1:NPIN];
                end
                A_ABLK: if (!lock_q) begin
                    cfg_q.ab_en   <= wdata_i[0];
                    cfg_q.ab_mask <= wdata_i[NKEY:1];
                    cfg_q.ab_val  <= wdata_i[2*NKEY:NKEY+1];
                end
                A_HOLD:    if (!lock_q) hold_q <= wdata_i;
                A_LOCK:    if (wdata_i[0]) lock_q <= 1'b1;
                default:   ;
            endcase
        end
    end

    assign cfg_o  = cfg_q;
    assign hold_o = hold_q;
    assign lock_o = lock_q;

    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    assert_locked_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(cfg_q.legal0) && $stable(cfg_q.legal1) &&
                    $stable(cfg_q.inv_in) && $stable(cfg_q.inv_out) &&
                    $stable(cfg_q.ab_en) && $stable(hold_q)));
endmodule

// File: rtl/pin_guard_autoblk.sv
// Automatic key block.
// Once armed by a high power input, the block counts consecutive low samples and
// raises its output after hold+1 of them. The output drops at once when power is high.
// Assumes the power input is already synchronous and polarity-corrected.
module pin_guard_autoblk #(
    parameter int DBW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_i,
    input  logic           en_i,
    input  logic [DBW-1:0] hold_i,
    output logic           active_o
);
    logic [DBW-1:0] cnt_q;
    logic           armed_q;
    logic           blk_q;

    // Arm on a high sample, count low samples, latch the block at the hold limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            blk_q   <= 1'b0;
        end else if (pwr_i) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
            blk_q   <= 1'b0;
        end else if (!en_i) begin
            cnt_q   <= '0;
            blk_q   <= 1'b0;
        end else if (armed_q && !blk_q) begin
            if (cnt_q >= hold_i) blk_q <= 1'b1;
            else                 cnt_q <= cnt_q + 1'b1;
        end
    end

    // Release combinationally as soon as the power input is high again.
    assign active_o = blk_q && !pwr_i;

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_i |-> !active_o);

    assert_needs_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_q) |-> !$past(pwr_i));

    assert_armed_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        blk_q |-> armed_q);
endmodule

// File: rtl/pin_guard_lane.sv
// Output lane: picks a legal software override, else a hardware override,
// else the default. Output inversion is applied to the chosen value.
// Assumes all select inputs are stable within the cycle.
module pin_guard_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_en_i,
    input  logic sw_val_i,
    input  logic legal0_i,
    input  logic legal1_i,
    input  logic hw_en_i,
    input  logic hw_val_i,
    input  logic dflt_i,
    input  logic inv_i,
    output logic out_o
);
    logic sw_ok;
    logic pre;

    // Priority selection followed by output polarity.
    always_comb begin
        sw_ok = sw_en_i && (sw_val_i ? legal1_i : legal0_i);
        if (sw_ok)        pre = sw_val_i;
        else if (hw_en_i) pre = hw_val_i;
        else              pre = dflt_i;
        out_o = pre ^ inv_i;
    end

    assert_sw_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en_i && sw_val_i && legal1_i) |-> (out_o == !inv_i));

    assert_illegal_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en_i && !(sw_val_i ? legal1_i : legal0_i) && !hw_en_i)
            |-> (out_o == (dflt_i ^ inv_i)));
endmodule

// File: rtl/pin_guard.sv
// Top: input inversion, automatic key block, and six priority lanes.
// Lanes 0-3 pass the inputs through; lane 4 drives the reset output and lane 5
// drives the write-protect output. Assumes pin_i is synchronous to clk.
module pin_guard
    import pin_guard_pkg::*;
#(
    parameter int DBW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [3:0]     pin_i,
    input  logic           ext_rst_req_i,
    input  logic           cfg_we_i,
    input  logic [2:0]     cfg_addr_i,
    input  logic [DBW-1:0] cfg_wdata_i,
    output logic [3:0]     pin_o,
    output logic           xrst_l_o,
    output logic           wp_l_o
);
    cfg_t             cfg;
    logic [DBW-1:0]   hold;
    logic             lock;
    logic [NPIN-1:0]  pin_eff;
    logic             blk_active;
    logic [NLANE-1:0] lane_out;

    pin_guard_cfg #(.DBW(DBW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
        .wdata_i(cfg_wdata_i), .cfg_o(cfg), .hold_o(hold), .lock_o(lock)
    );

    // Input polarity correction ahead of any detection logic.
    assign pin_eff = pin_i ^ cfg.inv_in;

    pin_guard_autoblk #(.DBW(DBW)) u_ablk (
        .clk(clk), .rst_n(rst_n), .pwr_i(pin_eff[0]), .en_i(cfg.ab_en),
        .hold_i(hold), .active_o(blk_active)
    );

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        logic hw_en, hw_val, dflt, inv;
        if (i == 0) begin : g_pwr
            assign hw_en = 1'b0;
            assign hw_val = 1'b0;
            assign dflt = pin_eff[i];
            assign inv = cfg.inv_out[i];
        end else if (i < NPIN) begin : g_key
            assign hw_en = blk_active && cfg.ab_mask[i-1];
            assign hw_val = cfg.ab_val[i-1];
            assign dflt = pin_eff[i];
            assign inv = cfg.inv_out[i];
        end else if (i == LANE_XRST) begin : g_xrst
            assign hw_en = ext_rst_req_i;
            assign hw_val = 1'b0;
            assign dflt = 1'b1;
            assign inv = 1'b0;
        end else begin : g_wp
            assign hw_en = 1'b0;
            assign hw_val = 1'b0;
            assign dflt = 1'b0;
            assign inv = 1'b0;
        end
        pin_guard_lane u_lane (
            .clk(clk), .rst_n(rst_n),
            .sw_en_i(cfg.ovr_en[i]), .sw_val_i(cfg.ovr_val[i]),
            .legal0_i(cfg.legal0[i]), .legal1_i(cfg.legal1[i]),
            .hw_en_i(hw_en), .hw_val_i(hw_val), .dflt_i(dflt), .inv_i(inv),
            .out_o(lane_out[i])
        );
    end

    assign pin_o    = lane_out[NPIN-1:0];
    assign xrst_l_o = lane_out[LANE_XRST];
    assign wp_l_o   = lane_out[LANE_WP];

    assert_xrst_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rst_req_i && !cfg.ovr_en[LANE_XRST]) |-> !xrst_l_o);

    assert_wp_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.ovr_en[LANE_WP] |-> !wp_l_o);

    assert_lock_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(cfg.ab_mask) && $stable(cfg.ab_val));
endmodule

// File: tb/tb_pin_guard.sv
module tb_pin_guard;
    localparam int CLK_PERIOD = 10;
    localparam int DBW = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [3:0]     pin_i = 4'b1010;
    logic           ext_rst_req_i = 1'b0;
    logic           cfg_we_i = 1'b0;
    logic [2:0]     cfg_addr_i = 3'd0;
    logic [DBW-1:0] cfg_wdata_i = '0;
    logic [3:0]     pin_o;
    logic           xrst_l_o;
    logic           wp_l_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    pin_guard #(.DBW(DBW)) dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .ext_rst_req_i(ext_rst_req_i),
        .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
        .pin_o(pin_o), .xrst_l_o(xrst_l_o), .wp_l_o(wp_l_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DBW-1:0] d);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Priority model: legal software override, hardware override, corrected input.
    function automatic logic [3:0] model(input logic [3:0] pin, ii, io, l0, l1, en, val, hwen, hwv);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) begin
            logic pre;
            if (en[i] && (val[i] ? l1[i] : l0[i])) pre = val[i];
            else if (hwen[i])                      pre = hwv[i];
            else                                   pre = pin[i] ^ ii[i];
            r[i] = pre ^ io[i];
        end
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired (all requirements)");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R7 R8: reset state
        chk("R7 reset xrst", {7'd0, xrst_l_o}, 8'd0);
        chk("R8 reset wp", {7'd0, wp_l_o}, 8'd0);
        chk("R1 reset passthrough", {4'd0, pin_o}, {4'd0, 4'b1010});

        // R1: every inversion pair against every input pattern
        for (int inv = 0; inv < 256; inv++) begin
            wr(3'd4, DBW'(inv));
            for (int p = 0; p < 16; p++) begin
                @(negedge clk);
                pin_i = 4'(p); #1;
                chk("R1 inversion", {4'd0, pin_o},
                    {4'd0, 4'(p) ^ 4'(inv) ^ 4'(inv >> 4)});
            end
        end

        // R2 R3 R5: legal masks x override values, with varied enables and inversion
        for (int lg = 0; lg < 256; lg++) begin
            wr(3'd0, DBW'({2'b11, 4'(lg)}));
            wr(3'd1, DBW'({2'b00, 4'(lg >> 4)}));
            for (int v = 0; v < 16; v++) begin
                logic [3:0] en, io, ii, pp;
                en = 4'(v) ^ 4'(lg) ^ 4'h6;
                io = 4'(v) ^ 4'(lg >> 4);
                ii = 4'(v) + 4'(lg);
                pp = 4'(v) ^ 4'h9;
                wr(3'd2, DBW'({2'b11, en}));
                wr(3'd3, DBW'({2'b00, 4'(v)}));
                wr(3'd4, DBW'({io, ii}));
                pin_i = pp; #1;
                chk("R2 R3 R5 override sweep", {4'd0, pin_o},
                    {4'd0, model(pp, ii, io, 4'(lg), 4'(lg >> 4), en, 4'(v), 4'd0, 4'd0)});
            end
        end

        // R7 R3 R4: reset output priority
        wr(3'd2, 16'h0020);
        #1; chk("R7 xrst released", {7'd0, xrst_l_o}, 8'd1);
        ext_rst_req_i = 1'b1; #1;
        chk("R7 hw request", {7'd0, xrst_l_o}, 8'd0);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0010);
        wr(3'd3, 16'h0010);
        wr(3'd2, 16'h0030);
        #1; chk("R4 sw beats hw request", {7'd0, xrst_l_o}, 8'd1);
        wr(3'd1, 16'h0000);
        #1; chk("R3 illegal xrst override", {7'd0, xrst_l_o}, 8'd0);
        ext_rst_req_i = 1'b0;
        // R8: write-protect default and legal release
        wr(3'd2, 16'h0000);
        #1; chk("R8 wp default", {7'd0, wp_l_o}, 8'd0);
        wr(3'd1, 16'h0020);
        wr(3'd3, 16'h0020);
        wr(3'd2, 16'h0020);
        #1; chk("R2 wp override to 1", {7'd0, wp_l_o}, 8'd1);

        // R11: power held low from reset never arms the key block
        pin_i = 4'b1100;
        do_reset();
        wr(3'd5, 16'h001B);
        wr(3'd6, 16'h0000);
        repeat (6) @(negedge clk);
        #1; chk("R11 not armed", {4'd0, pin_o}, {4'd0, 4'b1100});

        // R9 R10: onset at hold+1 low samples for several hold times
        for (int t = 0; t < 4; t++) begin
            int hold;
            hold = (t == 3) ? 7 : t;
            wr(3'd6, DBW'(hold));
            @(negedge clk); pin_i = 4'b1101;
            @(negedge clk); pin_i = 4'b1100; #1;
            chk("R9 idle before count", {4'd0, pin_o}, {4'd0, 4'b1100});
            for (int k = 1; k <= hold + 3; k++) begin
                @(negedge clk); #1;
                chk("R9 onset", {4'd0, pin_o},
                    {4'd0, (k >= hold + 1) ? 4'b0110 : 4'b1100});
            end
            pin_i = 4'b1101; #1;
            chk("R10 immediate release", {4'd0, pin_o}, {4'd0, 4'b1101});
        end

        // R4: software beats active key block; R5 inversion on blocked key
        wr(3'd6, 16'h0000);
        @(negedge clk); pin_i = 4'b1101;
        @(negedge clk); pin_i = 4'b1100;
        repeat (2) @(negedge clk);
        #1; chk("R9 blocked", {4'd0, pin_o}, {4'd0, 4'b0110});
        wr(3'd1, 16'h0008);
        wr(3'd3, 16'h0008);
        wr(3'd2, 16'h0038);
        #1; chk("R4 sw beats key block", {4'd0, pin_o}, {4'd0, 4'b1110});
        wr(3'd4, 16'h0020);
        #1; chk("R9 R5 blocked key inverted", {4'd0, pin_o}, {4'd0, 4'b1100});
        pin_i = 4'b1101; #1;
        chk("R10 release with sw", {4'd0, pin_o}, {4'd0, 4'b1111});

        // R6: lock freezes protected fields, overrides stay writable
        do_reset();
        wr(3'd0, 16'h0031);
        wr(3'd7, 16'h0001);
        wr(3'd7, 16'h0000);
        wr(3'd1, 16'h003F);
        wr(3'd4, 16'h00F0);
        wr(3'd5, 16'h001B);
        pin_i = 4'b1111;
        wr(3'd3, 16'h0001);
        wr(3'd2, 16'h0031);
        #1; chk("R6 legal1 write ignored", {4'd0, pin_o}, {4'd0, 4'b1111});
        wr(3'd3, 16'h0000);
        #1; chk("R6 override writable", {4'd0, pin_o}, {4'd0, 4'b1110});
        @(negedge clk); pin_i = 4'b1110;
        repeat (3) @(negedge clk);
        #1; chk("R6 ablk write ignored", {4'd0, pin_o}, {4'd0, 4'b1110});
        chk("R6 xrst still low", {7'd0, xrst_l_o}, 8'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule